// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor Core

This core runs a small load/store and arithmetic instruction set out of an external 32-word by 8-bit memory. Every instruction starts with an opcode fetch, followed by a decode cycle. Depending on the instruction, one memory operand cycle and one register writeback cycle may follow. The core has seven 8-bit general registers, one of which serves as the accumulator for arithmetic and direct transfers. A further operand, "M", is the memory word addressed by the low five bits of register L.

The core connects to memory through a 5-bit address, a shared bidirectional 8-bit data bus and two active-low strobes. It drives the bus only while a write is in progress. A halt opcode stops the core until reset. Debug outputs show the program counter, the instruction register and the full register file, so that a bench or a host can follow execution.

Top module: `acc_core`

## Requirements
- R1: After reset the PC is 0, every register and the IR are 0, the core is not halted, and the first fetch reads address 0.
- R2: Registers use 3-bit codes B=000, C=001, D=010, E=011, H=100, L=101, A=111. Opcode 01 ddd sss (neither field 110) copies register sss into register ddd.
- R3: Code 110 in a register field selects M, the memory word at the low 5 bits of L. The top 3 bits of L are ignored. 01 110 sss writes a register to M, and 01 ddd 110 loads a register from M.
- R4: 10 000 sss adds the source (register or M) to A, and 10 010 sss subtracts it from A. Both results wrap modulo 256.
- R5: 11 1 aaaaa stores A to address aaaaa, and 00 1 aaaaa loads A from that address.
- R6: 00 ddd 110 (ddd not 110) loads the byte that follows the opcode into register ddd. The PC then continues after that byte.
- R7: An opcode that fits both the immediate form (R6) and the direct-load form (R5) executes as the immediate load. 00 110 110 is a direct load from address 22.
- R8: Any opcode with no defined meaning, including 00000000, changes no register and no memory word, and execution continues at the next byte.
- R9: Opcode 01 110 110 halts the core. From then until reset, the PC and registers do not change and both strobes stay high.
- R10: The PC advances by exactly one per consumed byte and wraps from 31 to 0.
- R11: The read and write strobes are never low together, and a write strobe lasts one cycle. The core drives the data bus only while its write strobe is low and releases it otherwise. Read data is captured at the clock edge that ends the read-strobe cycle.
- R12: The 25-byte self-check program ends halted with A=2, B=30, C=5, H=21, L=20 and memory word 23 equal to 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 5 | Memory word address |
| mem_data | inout | 8 | Shared data bus to memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | High while the core drives mem_data |
| halted | output | 1 | Core has executed a halt |
| dbg_pc | output | 5 | Program counter |
| dbg_ir | output | 8 | Instruction register |
| dbg_regs | output | 64 | Register file, byte n holds register code n (byte 6 is always 0) |

## Verification
During an immediate load, the operand read at the PC address and the PC increment take place in the same operand cycle. If the increment came early or late, the wrong byte would be loaded, or the next opcode would be fetched from the immediate byte. Short vector programs that place an immediate load just before a halt provoke this case. Each is judged by the loaded accumulator value and by the PC resting at 4 after the halt. The full program additionally overlaps this with the immediate-versus-direct precedence: opcodes 2E and 3E must take the immediate path.

// File: rtl/acc_core.sv
module acc_core (
  input  logic       clk,
  input  logic       rst_n,
  output logic [4:0] mem_addr,
  inout  wire  [7:0] mem_data,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       bus_oe,
  output logic       halted,
  output logic [4:0] dbg_pc,
  output logic [7:0] dbg_ir,
  output logic [63:0] dbg_regs
);
  localparam logic [2:0] MCODE = 3'b110;
  localparam int ACC = 7;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OPER, S_EXEC, S_HALT} state_t;

  state_t     st;
  logic [4:0] pc;
  logic [7:0] ir, opr;
  logic [7:0] rf [8];

  wire [2:0] fd = ir[5:3];
  wire [2:0] fs = ir[2:0];

  wire is_hlt = ir == 8'h76;
  wire is_mov = ir[7:6] == 2'b01 && !is_hlt;
  wire is_mvi = ir[7:6] == 2'b00 && fs == MCODE && fd != MCODE;
  wire is_lda = ir[7:6] == 2'b00 && ir[5] && !is_mvi;
  wire is_sta = ir[7:6] == 2'b11 && ir[5];
  wire is_alu = ir[7:6] == 2'b10 && (fd == 3'b000 || fd == 3'b010);

  wire rd_op  = is_mvi || is_lda || ((is_mov || is_alu) && fs == MCODE);
  wire wr_op  = is_sta || (is_mov && fd == MCODE);
  wire reg_op = (is_mov && fd != MCODE) || is_mvi || is_lda || is_alu;

  wire [7:0] opnd = (is_lda || fs == MCODE) ? opr : rf[fs];
  wire [7:0] wval = !is_alu ? opnd : (ir[4] ? rf[ACC] - opnd : rf[ACC] + opnd);
  wire [2:0] dst  = (is_lda || is_alu) ? 3'(ACC) : fd;

  wire [4:0] oper_addr = is_mvi ? pc : (is_lda || is_sta) ? ir[4:0] : rf[5][4:0];
  wire [7:0] wdata     = is_sta ? rf[ACC] : rf[fs];

  assign mem_rd_n = !(st == S_FETCH || (st == S_OPER && rd_op));
  assign mem_wr_n = !(st == S_OPER && wr_op);
  assign bus_oe   = !mem_wr_n;
  assign mem_addr = (st == S_OPER) ? oper_addr : pc;
  assign mem_data = bus_oe ? wdata : 8'bz;
  assign halted   = st == S_HALT;
  assign dbg_pc   = pc;
  assign dbg_ir   = ir;

  always_comb
    for (int i = 0; i < 8; i++) dbg_regs[i*8 +: 8] = rf[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= '0;
      ir  <= '0;
      opr <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem_data;
          pc <= pc + 5'd1;
          st <= S_DEC;
        end
        S_DEC:
          if (is_hlt)               st <= S_HALT;
          else if (rd_op || wr_op)  st <= S_OPER;
          else if (reg_op)          st <= S_EXEC;
          else                      st <= S_FETCH;
        S_OPER: begin
          if (rd_op)  opr <= mem_data;
          if (is_mvi) pc  <= pc + 5'd1;
          st <= wr_op ? S_FETCH : S_EXEC;
        end
        S_EXEC: begin
          rf[dst] <= wval;
          st <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        halted,
  input logic [4:0]  dbg_pc,
  input logic [63:0] dbg_regs
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_pc == 5'd0 && dbg_regs == 64'd0 && !halted));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |=> mem_wr_n);

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(dbg_pc) && $stable(dbg_regs) && halted));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (mem_rd_n && mem_wr_n));

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_pc != $past(dbg_pc)) |-> (dbg_pc == $past(dbg_pc) + 5'd1));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .halted(halted), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  wire  [7:0] mem_data;
  logic [4:0] mem_addr;
  logic mem_rd_n, mem_wr_n, bus_oe, halted;
  logic [4:0] dbg_pc;
  logic [7:0] dbg_ir;
  logic [63:0] dbg_regs;

  int n_run = 0;
  int n_fail = 0;
  int bus_bad = 0;

  always #2 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .bus_oe(bus_oe),
    .halted(halted), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_regs(dbg_regs)
  );

  logic [7:0] mem [32];
  logic       ld_en = 1'b0;
  logic [4:0] ld_a = '0;
  logic [7:0] ld_d = '0;

  assign mem_data = !mem_rd_n ? mem[mem_addr] : 8'bz;

  always @(posedge clk)
    if (ld_en) mem[ld_a] <= ld_d;
    else if (!mem_wr_n) mem[mem_addr] <= mem_data;

  always @(negedge clk) begin
    if (rst_n && mem_rd_n && mem_wr_n && mem_data !== 8'bzzzzzzzz) bus_bad++;
    if (rst_n && !mem_wr_n && !bus_oe) bus_bad++;
  end

  // {imm, opcode, expected A}; program: 3E imm op 76, rest A0+addr
  localparam logic [23:0] VEC [11] = '{
    {8'h05, 8'h87, 8'h0A},   // R4 ADD A
    {8'h03, 8'h97, 8'h00},   // R4 SUB A
    {8'hF0, 8'h86, 8'h2E},   // R4 ADD M wrap, M=mem[0]=3E
    {8'h10, 8'h96, 8'hD2},   // R4 SUB M borrow wrap
    {8'h07, 8'h80, 8'h07},   // R4 ADD B (B=0)
    {8'h09, 8'h3A, 8'hBA},   // R5 LDA 26
    {8'h09, 8'h36, 8'hB6},   // R7 00110110 is LDA 22
    {8'h01, 8'h88, 8'h01},   // R8 undefined ALU code
    {8'h02, 8'h7E, 8'h3E},   // R3 MOV A,M
    {8'h04, 8'h00, 8'h04},   // R8 NOP
    {8'h06, 8'hC5, 8'h06}    // R8 undefined 11 0 xxxxx
  };

  localparam logic [7:0] PROG [25] = '{
    8'h35, 8'h47, 8'h80, 8'h0E, 8'h05, 8'h91, 8'h2E, 8'h18, 8'h66, 8'h6F,
    8'h74, 8'h3E, 8'h01, 8'h00, 8'h86, 8'h00, 8'h2E, 8'h14, 8'h96, 8'h76,
    8'h14, 8'h1E, 8'h00, 8'h00, 8'h15
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] a, input logic [7:0] d);
    ld_a = a; ld_d = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_run(output bit ok);
    rst_n = 1'b1;
    ok = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (halted) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [7:0] rg(input int code);
    return dbg_regs[code*8 +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    logic [4:0]  pc_h;
    logic [63:0] rg_h;
    bit wrapped;

    // R1 reset state
    do_reset();
    for (int a = 0; a < 32; a++) load(5'(a), 8'h00);
    @(negedge clk);
    chk("R1 pc", 64'(dbg_pc), 64'd0);
    chk("R1 regs", dbg_regs, 64'd0);
    chk("R1 ir", 64'(dbg_ir), 64'd0);
    chk("R1 halted", 64'(halted), 64'd0);
    chk("R1 fetch addr", 64'({mem_rd_n, mem_wr_n, mem_addr}), 64'({1'b0, 1'b1, 5'd0}));

    // R10 PC wrap over an all-NOP memory
    rst_n = 1'b1;
    wrapped = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (dbg_pc == 5'd31) begin
        while (dbg_pc == 5'd31) @(negedge clk);
        wrapped = 1'b1;
        break;
      end
    end
    chk("R10 wrap reached", 64'(wrapped), 64'd1);
    chk("R10 pc after 31", 64'(dbg_pc), 64'd0);
    chk("R8 nops keep regs", dbg_regs, 64'd0);

    // vector table
    foreach (VEC[v]) begin
      do_reset();
      for (int a = 0; a < 32; a++) load(5'(a), 8'(8'hA0 + a));
      load(5'd0, 8'h3E);
      load(5'd1, VEC[v][23:16]);
      load(5'd2, VEC[v][15:8]);
      load(5'd3, 8'h76);
      release_run(ok);
      chk($sformatf("R4/R5/R7/R8 vec%0d halted", v), 64'(ok), 64'd1);
      chk($sformatf("R4/R5/R7/R8 vec%0d A", v), 64'(rg(7)), 64'(VEC[v][7:0]));
      chk($sformatf("R6 vec%0d pc", v), 64'(dbg_pc), 64'd4);
    end

    // R2 R6: MVI B,5A ; MOV D,B ; MOV E,D ; HLT
    do_reset();
    load(5'd0, 8'h06); load(5'd1, 8'h5A); load(5'd2, 8'h50);
    load(5'd3, 8'h5A); load(5'd4, 8'h76);
    release_run(ok);
    chk("R2 D", 64'(rg(2)), 64'h5A);
    chk("R2 E", 64'(rg(3)), 64'h5A);
    chk("R6 pc", 64'(dbg_pc), 64'd5);

    // R5 STA 25 ; R3 MOV M,A with L=E3 (low bits 3)
    do_reset();
    load(5'd0, 8'h3E); load(5'd1, 8'h55); load(5'd2, 8'hF9);
    load(5'd3, 8'h2E); load(5'd4, 8'hE3); load(5'd5, 8'h77);
    load(5'd6, 8'h76); load(5'd25, 8'h00);
    release_run(ok);
    chk("R5 STA mem25", 64'(mem[25]), 64'h55);
    chk("R3 MOV M,A mem3 via L low bits", 64'(mem[3]), 64'h55);

    // R12 full program, then R9 freeze
    do_reset();
    for (int a = 0; a < 32; a++) load(5'(a), 8'h00);
    foreach (PROG[i]) load(5'(i), PROG[i]);
    release_run(ok);
    chk("R12 halted", 64'(ok), 64'd1);
    chk("R12 A", 64'(rg(7)), 64'd2);
    chk("R12 B", 64'(rg(0)), 64'd30);
    chk("R12 C", 64'(rg(1)), 64'd5);
    chk("R12 H", 64'(rg(4)), 64'd21);
    chk("R12 L", 64'(rg(5)), 64'd20);
    chk("R12 mem23", 64'(mem[23]), 64'd21);
    chk("R7 D E untouched", 64'({rg(2), rg(3)}), 64'd0);
    chk("R9 pc at halt", 64'(dbg_pc), 64'd20);
    pc_h = dbg_pc;
    rg_h = dbg_regs;
    repeat (12) @(negedge clk);
    chk("R9 pc frozen", 64'(dbg_pc), 64'(pc_h));
    chk("R9 regs frozen", dbg_regs, rg_h);
    chk("R9 strobes high", 64'({mem_rd_n, mem_wr_n}), 64'b11);

    chk("R11 bus released when idle", 64'(bus_bad), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule